// File: doc/BRIEF.md
# Configuration Command Port

This block gives software a small command channel to a board-level power and reset controller. It sits on a simple register bus as a slave and holds three 32-bit words: a free-form data word, a command word and a two-bit result word. A store to the command word counts as issuing a command. The block recognises two command codes. One becomes a shutdown request pulse and the other becomes a reboot request pulse. Every other code is reported back as an error.

The channel is only present on one board type, which is chosen by a parameter. The board type currently fitted arrives on an input. On any other board the three words behave like unmapped space. Reads return zero, writes are dropped, and the stored contents stay as they were. Reads are combinational from the stored words. Writes take effect at the clock edge where they are presented. A request pulse is high for exactly the one cycle after the edge that stored the command.

Top module: `cfgcmd_ctrl`

## Requirements
- R1: After reset the data, command and result words all read 0, and both request outputs are low.
- R2: The data word at offset 0xA0 stores and reads back all 32 bits written to it.
- R3: A write to the command word at offset 0xA4 stores the written value with bits 19 and 18 cleared, and reads back that way.
- R4: A command write makes the result word at offset 0xA8 read 1 (bit 0 = complete) when the stripped value is a recognised code.
- R5: A stripped command value of 0xC0800000 raises `shutdown_req` for exactly the one cycle after the write edge, and `reboot_req` stays low.
- R6: A stripped command value of 0xC0900000 raises `reboot_req` for exactly the one cycle after the write edge, and `shutdown_req` stays low.
- R7: Any other stripped command value makes the result word read 3 (bit 1 = error, bit 0 = complete), and neither request output pulses.
- R8: A direct write to the result word keeps only data bits 1:0, and bits 31:2 read 0.
- R9: While `board_id` differs from the active board type (default 0x190), reads of the three offsets return 0, writes to them change no stored word, and writes raise no request.
- R10: Bits 19:18 are stripped before the command is decoded, so 0xC08C0000 is treated as a shutdown command and 0xC09C0000 as a reboot command.
- R11: A read of any offset other than the three words returns 0.
- R12: `shutdown_req` and `reboot_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| board_id | input | BOARD_W (12) | Board type currently fitted |
| bus_valid | input | 1 | Bus access present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; combinational, 0 when not reading a live word |
| shutdown_req | output | 1 | One-cycle shutdown request |
| reboot_req | output | 1 | One-cycle reboot request |

## Verification
The hardest case to reach is the decode of a command whose bits 19:18 are set. A write like that has to be stripped and then matched in the same edge. The result has to show up at once in the stored command, in the result word and on the correct pulse output. The stimulus writes 0xC08C0000 and 0xC09C0000 and watches the pulse in the single cycle after the edge. It then reads both the command and result words back. A second hard case is the board-type gate. The stimulus fills all three words on the active board, then changes `board_id` and tries writes and commands. After switching back, it reads the words to confirm nothing changed while they were hidden.

// File: rtl/cfgcmd_pkg.sv
package cfgcmd_pkg;
  localparam int CFG_W  = 32;
  localparam int OFS_W  = 12;
  localparam int NREG   = 3;
  localparam int STRIP_LO = 18;
  localparam int STRIP_HI = 19;

  localparam logic [CFG_W-1:0] CODE_SHUTDOWN = 32'hC080_0000;
  localparam logic [CFG_W-1:0] CODE_REBOOT   = 32'hC090_0000;

  typedef enum logic [1:0] {SEL_NONE, SEL_DATA, SEL_CTL, SEL_STAT} reg_sel_e;
  typedef enum logic [1:0] {CMD_OTHER, CMD_SHUT, CMD_BOOT} cmd_kind_e;

  // Byte offset of register slot i (0 data, 1 command, 2 result)
  function automatic logic [OFS_W-1:0] slot_offset(input int i);
    return OFS_W'(12'hA0 + 4 * i);
  endfunction

  // Command value with the reserved pair of bits cleared
  function automatic logic [CFG_W-1:0] strip_cmd(input logic [CFG_W-1:0] v);
    logic [CFG_W-1:0] r;
    r = v;
    r[STRIP_HI:STRIP_LO] = '0;
    return r;
  endfunction

  function automatic cmd_kind_e classify(input logic [CFG_W-1:0] stripped);
    if (stripped == CODE_SHUTDOWN) return CMD_SHUT;
    if (stripped == CODE_REBOOT)   return CMD_BOOT;
    return CMD_OTHER;
  endfunction

  // Result word after a command: bit0 complete, bit1 error
  function automatic logic [1:0] result_of(input cmd_kind_e k);
    return (k == CMD_OTHER) ? 2'b11 : 2'b01;
  endfunction
endpackage

// File: rtl/cfgcmd_decode.sv
module cfgcmd_decode
  import cfgcmd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BOARD_W = 12,
  parameter logic [BOARD_W-1:0] ACTIVE_BOARD = 12'h190
) (
  input  logic [BOARD_W-1:0] board_id,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [ADDR_W-1:0]  bus_addr,
  output logic               board_ok,
  output reg_sel_e           sel,
  output logic               wr_en
);
  logic [NREG-1:0] hit;

  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign hit[i] = (bus_addr == ADDR_W'(slot_offset(i)));
  end

  assign board_ok = (board_id == ACTIVE_BOARD);

  always_comb begin
    sel = SEL_NONE;
    if (bus_valid && board_ok) begin
      if (hit[0])      sel = SEL_DATA;
      else if (hit[1]) sel = SEL_CTL;
      else if (hit[2]) sel = SEL_STAT;
    end
  end

  assign wr_en = bus_write && (sel != SEL_NONE);
endmodule

// File: rtl/cfgcmd_action.sv
module cfgcmd_action
  import cfgcmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr_evt,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] stripped,
  output logic [1:0]       cmd_result,
  output logic             shutdown_req,
  output logic             reboot_req
);
  cmd_kind_e kind;

  assign stripped   = strip_cmd(wdata);
  assign kind       = classify(stripped);
  assign cmd_result = result_of(kind);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shutdown_req <= 1'b0;
      reboot_req   <= 1'b0;
    end else begin
      shutdown_req <= ctl_wr_evt && (kind == CMD_SHUT);
      reboot_req   <= ctl_wr_evt && (kind == CMD_BOOT);
    end
  end
endmodule

// File: rtl/cfgcmd_regs.sv
module cfgcmd_regs
  import cfgcmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  reg_sel_e         sel,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wdata,
  input  logic [CFG_W-1:0] stripped,
  input  logic [1:0]       cmd_result,
  output logic [CFG_W-1:0] data_q,
  output logic [CFG_W-1:0] ctl_q,
  output logic [1:0]       stat_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ctl_q  <= '0;
      stat_q <= '0;
    end else if (wr_en) begin
      unique case (sel)
        SEL_DATA: data_q <= wdata;
        SEL_CTL: begin
          ctl_q  <= stripped;
          stat_q <= cmd_result;
        end
        SEL_STAT: stat_q <= wdata[1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cfgcmd_ctrl.sv
module cfgcmd_ctrl
  import cfgcmd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BOARD_W = 12,
  parameter logic [BOARD_W-1:0] ACTIVE_BOARD = 12'h190
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BOARD_W-1:0] board_id,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               shutdown_req,
  output logic               reboot_req
);
  logic             board_ok;
  reg_sel_e         sel;
  logic             wr_en;
  logic             ctl_wr_evt;
  logic [CFG_W-1:0] stripped;
  logic [1:0]       cmd_result;
  logic [CFG_W-1:0] data_q;
  logic [CFG_W-1:0] ctl_q;
  logic [1:0]       stat_q;

  cfgcmd_decode #(.ADDR_W(ADDR_W), .BOARD_W(BOARD_W), .ACTIVE_BOARD(ACTIVE_BOARD)) u_dec (
    .board_id(board_id), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .board_ok(board_ok), .sel(sel), .wr_en(wr_en)
  );

  assign ctl_wr_evt = wr_en && (sel == SEL_CTL);

  cfgcmd_action u_act (
    .clk(clk), .rst_n(rst_n), .ctl_wr_evt(ctl_wr_evt), .wdata(bus_wdata),
    .stripped(stripped), .cmd_result(cmd_result),
    .shutdown_req(shutdown_req), .reboot_req(reboot_req)
  );

  cfgcmd_regs u_regs (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .wdata(bus_wdata),
    .stripped(stripped), .cmd_result(cmd_result),
    .data_q(data_q), .ctl_q(ctl_q), .stat_q(stat_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (!bus_write) begin
      unique case (sel)
        SEL_DATA: bus_rdata = data_q;
        SEL_CTL:  bus_rdata = ctl_q;
        SEL_STAT: bus_rdata = {30'd0, stat_q};
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/cfgcmd_ctrl_chk.sv
module cfgcmd_ctrl_chk
  import cfgcmd_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             bus_valid,
  input logic             bus_write,
  input logic             board_ok,
  input logic             ctl_wr_evt,
  input logic [CFG_W-1:0] data_q,
  input logic [CFG_W-1:0] ctl_q,
  input logic [1:0]       stat_q,
  input logic [31:0]      bus_rdata,
  input logic             shutdown_req,
  input logic             reboot_req
);
  // R12
  req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(shutdown_req && reboot_req));

  // R5
  shut_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |-> ($past(ctl_wr_evt) && stat_q == 2'b01));

  // R6
  boot_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reboot_req |-> ($past(ctl_wr_evt) && stat_q == 2'b01));

  // R4
  cmd_completes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_evt |=> stat_q[0]);

  // R3
  ctl_stripped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[19:18] == 2'b00);

  // R9
  hidden_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !board_ok) |-> (bus_rdata == 32'd0));

  // R9
  hidden_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && !board_ok) |=>
      ($stable(data_q) && $stable(ctl_q) && $stable(stat_q)));
endmodule

bind cfgcmd_ctrl cfgcmd_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .board_ok(board_ok), .ctl_wr_evt(ctl_wr_evt), .data_q(data_q), .ctl_q(ctl_q),
  .stat_q(stat_q), .bus_rdata(bus_rdata), .shutdown_req(shutdown_req),
  .reboot_req(reboot_req)
);

// File: tb/cfgcmd_ctrl_tb_top.sv
module cfgcmd_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] board_id = 12'h190;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        shutdown_req;
  logic        reboot_req;

  int n_checks = 0;
  int n_fail = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } rd_item_t;
  rd_item_t sb_q[$];

  always #4 clk = ~clk;

  cfgcmd_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .board_id(board_id), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .shutdown_req(shutdown_req), .reboot_req(reboot_req)
  );

  // Monitor: compares each read against the scoreboard head
  always @(negedge clk) begin
    if (bus_valid && !bus_write) begin
      rd_item_t it;
      n_checks++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard empty: actual %h expected none", bus_rdata);
      end else begin
        it = sb_q.pop_front();
        if (bus_rdata !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic do_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    sb_q.push_back('{exp: exp, tag: tag});
    @(posedge clk); #1;
    bus_valid = 1'b0;
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic chk_pulses(input logic sd, input logic rb, input string tag);
    @(negedge clk);
    n_checks++;
    if (shutdown_req !== sd || reboot_req !== rb) begin
      n_fail++;
      $display("FAIL %s: actual sd=%b rb=%b expected sd=%b rb=%b",
               tag, shutdown_req, reboot_req, sd, rb);
    end
  endtask

  // Expected stripped command computed independently of the design
  function automatic logic [31:0] model_strip(input logic [31:0] v);
    return v & ~(32'h3 << 18);
  endfunction

  initial begin
    #200000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk_pulses(1'b0, 1'b0, "R1 pulses after reset");
    do_read(12'hA0, 32'd0, "R1 data reset");
    do_read(12'hA4, 32'd0, "R1 ctl reset");
    do_read(12'hA8, 32'd0, "R1 stat reset");

    // R2 data word
    do_write(12'hA0, 32'hDEAD_BEEF);
    do_read(12'hA0, 32'hDEAD_BEEF, "R2 data rw");
    do_write(12'hA0, 32'h1357_9BDF);
    do_read(12'hA0, 32'h1357_9BDF, "R2 data rw second");

    // R7 and R3: unknown command, all ones
    do_write(12'hA4, 32'hFFFF_FFFF);
    chk_pulses(1'b0, 1'b0, "R7 no pulse on unknown");
    do_read(12'hA4, model_strip(32'hFFFF_FFFF), "R3 ctl stripped");
    do_read(12'hA8, 32'd3, "R7 error status");

    // R5 shutdown
    do_write(12'hA4, 32'hC080_0000);
    chk_pulses(1'b1, 1'b0, "R5 shutdown pulse");
    chk_pulses(1'b0, 1'b0, "R5 shutdown one cycle");
    do_read(12'hA8, 32'd1, "R4 complete after shutdown");
    do_read(12'hA4, 32'hC080_0000, "R3 ctl shutdown value");

    // R8 direct status write
    do_write(12'hA8, 32'hFFFF_FFFE);
    do_read(12'hA8, 32'd2, "R8 status low bits only");

    // R6 reboot
    do_write(12'hA4, 32'hC090_0000);
    chk_pulses(1'b0, 1'b1, "R6 reboot pulse");
    chk_pulses(1'b0, 1'b0, "R6 reboot one cycle");
    do_read(12'hA8, 32'd1, "R4 complete after reboot");

    // R10 stripped bits before decode
    do_write(12'hA4, 32'hC08C_0000);
    chk_pulses(1'b1, 1'b0, "R10 shutdown with bits 19:18 set");
    do_read(12'hA4, model_strip(32'hC08C_0000), "R10 ctl readback");
    do_read(12'hA8, 32'd1, "R10 status complete");
    do_write(12'hA4, 32'hC09C_0000);
    chk_pulses(1'b0, 1'b1, "R10 reboot with bits 19:18 set");

    // R7 near-miss code
    do_write(12'hA4, 32'hC080_0001);
    chk_pulses(1'b0, 1'b0, "R7 near miss no pulse");
    do_read(12'hA8, 32'd3, "R7 near miss error");

    // R11 unmapped offsets
    do_read(12'h040, 32'd0, "R11 unmapped read");
    do_read(12'hAC, 32'd0, "R11 unmapped above");

    // R9 hidden on another board
    board_id = 12'h182;
    do_read(12'hA0, 32'd0, "R9 hidden data read");
    do_read(12'hA4, 32'd0, "R9 hidden ctl read");
    do_write(12'hA0, 32'h0000_1234);
    do_write(12'hA8, 32'h0000_0001);
    do_write(12'hA4, 32'hC080_0000);
    chk_pulses(1'b0, 1'b0, "R9 hidden command no pulse");
    board_id = 12'h190;
    do_read(12'hA0, 32'h1357_9BDF, "R9 data untouched");
    do_read(12'hA4, 32'hC080_0001, "R9 ctl untouched");
    do_read(12'hA8, 32'd3, "R9 stat untouched");

    repeat (2) @(posedge clk);
    if (sb_q.size() != 0) begin
      n_checks++;
      n_fail++;
      $display("FAIL scoreboard leftover: actual %0d expected 0", sb_q.size());
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule